// File: doc/BRIEF.md
# Single-Bit Alias Access Unit

This unit sits between a simple request port and a single-port memory of 32-bit words. It makes every bit of every word addressable as a whole word of its own in a second address window, the alias window. A read of an alias word returns the chosen bit in bit 0, with every other bit zero. A write to an alias word changes only that one bit of the target word.

The unit performs an alias write as a read of the target word, an update of one bit, and a write back. It keeps the request port stalled until the write back is done, so no other access can reach the word in between. Addresses outside the alias window go straight to the memory as plain word reads and writes. The memory model is part of the block, so its contents can be seen only through the request port.

Byte addresses are `ADDR_W` bits wide and the top bit selects the window. In the alias window, the target word index is the alias offset divided by 128, and the bit index is bits [6:2] of the offset. Each target word therefore spans 32 alias words, and consecutive bits are 4 bytes apart.

Top module: `bitalias_unit`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every memory word reads as zero.
- R2: A request whose address bit `ADDR_W-1` is 0 is a direct access to word index `req_addr[WIDX_W+1:2]`. Other address bits are ignored, and all 32 data bits are written or returned.
- R3: A request whose address bit `ADDR_W-1` is 1 is an alias access to word index `req_addr[WIDX_W+6:7]` and bit index `req_addr[6:2]`.
- R4: An alias read returns the selected bit of the target word in `rsp_rdata[0]`, with `rsp_rdata[31:1]` zero and `rsp_err` 0.
- R5: An alias write sets the selected bit to `req_wdata[0]` and leaves the other 31 bits of the target word unchanged. Bits [31:1] of the write data have no effect.
- R6: An alias request with `req_addr[1:0]` not 00 returns `rsp_err` = 1 and `rsp_rdata` = 0, and does not change the memory.
- R7: Counting clock edges after the accepting edge, `rsp_valid` is high for exactly one cycle, after 1 edge for an error, 2 for a direct write, 3 for any read and 4 for an alias write. Writes return `rsp_rdata` = 0.
- R8: `req_ready` is 0 from the accepting edge until the response cycle ends, so a request held on the port is not accepted until the previous access, including a full read-modify-write, has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle; request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data (alias writes use bit 0 only) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Misaligned alias access |

## Verification
A wrong bit index or word index in the alias decode shows up as a wrong bit 0 on the next alias read of a bit whose value differs from its neighbours. It shows up later as a corrupted word on a direct read. A write back that uses a stale or unmasked word changes other bits of the target word, and the next direct read of that word reveals it. A sequencing fault shows at once as a response on the wrong cycle, or as `req_ready` rising before the write back is done.

// File: rtl/bitalias_pkg.sv
package bitalias_pkg;

    localparam int WORD_W = 32;
    localparam int BIDX_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WAIT,
        ST_WRITE,
        ST_RESP
    } ba_state_e;

endpackage

// File: rtl/bitalias_decode.sv
module bitalias_decode #(
    parameter int ADDR_W = 16,
    parameter int WIDX_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_alias,
    output logic              misaligned,
    output logic [WIDX_W-1:0] direct_widx,
    output logic [WIDX_W-1:0] alias_widx,
    output logic [4:0]        alias_bidx
);
    // alias offset layout: [WIDX_W+6:7] word, [6:2] bit, [1:0] must be zero
    always_comb begin
        is_alias    = addr[ADDR_W-1];
        misaligned  = addr[1:0] != 2'b00;
        direct_widx = addr[WIDX_W+1:2];
        alias_widx  = addr[WIDX_W+6:7];
        alias_bidx  = addr[6:2];
    end
endmodule

// File: rtl/bitalias_mem.sv
module bitalias_mem #(
    parameter int WORDS  = 16,
    parameter int WIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [WIDX_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    logic [31:0] store_q [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) store_q[i] <= '0;
            rdata <= '0;
        end else if (en) begin
            if (we) store_q[addr] <= wdata;
            else    rdata         <= store_q[addr];
        end
    end
endmodule

// File: rtl/bitalias_ctrl.sv
module bitalias_ctrl
    import bitalias_pkg::*;
#(
    parameter int WIDX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [31:0]       req_wdata,
    input  logic              dec_alias,
    input  logic              dec_misaligned,
    input  logic [WIDX_W-1:0] dec_direct_widx,
    input  logic [WIDX_W-1:0] dec_alias_widx,
    input  logic [4:0]        dec_alias_bidx,
    output logic              mem_en,
    output logic              mem_we,
    output logic [WIDX_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);
    typedef struct packed {
        ba_state_e         st;
        logic              write;
        logic              alias_acc;
        logic              err;
        logic [WIDX_W-1:0] widx;
        logic [4:0]        bidx;
        logic              newbit;
        logic [31:0]       word;
        logic [31:0]       orig;
    } ctrl_t;

    ctrl_t s_d, s_q;

    always_comb begin
        logic [31:0] merged;
        s_d       = s_q;
        merged    = mem_rdata;
        req_ready = (s_q.st == ST_IDLE);
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = s_q.widx;
        mem_wdata = s_q.word;
        rsp_valid = 1'b0;
        rsp_rdata = s_q.word;
        rsp_err   = s_q.err;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.write     = req_write;
                    s_d.alias_acc = dec_alias;
                    s_d.err       = dec_alias && dec_misaligned;
                    s_d.widx      = dec_alias ? dec_alias_widx : dec_direct_widx;
                    s_d.bidx      = dec_alias_bidx;
                    s_d.newbit    = req_wdata[0];
                    s_d.word      = (req_write && !dec_alias) ? req_wdata : '0;
                    s_d.orig      = '0;
                    if (dec_alias && dec_misaligned)  s_d.st = ST_RESP;
                    else if (req_write && !dec_alias) s_d.st = ST_WRITE;
                    else                              s_d.st = ST_READ;
                end
            end
            ST_READ: begin
                mem_en = 1'b1;
                s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                s_d.orig = mem_rdata;
                if (s_q.alias_acc && s_q.write) begin
                    merged[s_q.bidx] = s_q.newbit;
                    s_d.word = merged;
                    s_d.st   = ST_WRITE;
                end else if (s_q.alias_acc) begin
                    s_d.word = {31'b0, mem_rdata[s_q.bidx]};
                    s_d.st   = ST_RESP;
                end else begin
                    s_d.word = mem_rdata;
                    s_d.st   = ST_RESP;
                end
            end
            ST_WRITE: begin
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                s_d.word = '0;
                s_d.st   = ST_RESP;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                s_d.st    = ST_IDLE;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R7
    AST_ALIAS_READ_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && s_q.alias_acc && !s_q.write) |-> (rsp_rdata[31:1] == 31'b0)); // R4
    AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && s_q.alias_acc) |-> ($countones(mem_wdata ^ s_q.orig) <= 1)); // R5
    AST_RMW_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && s_q.alias_acc) |-> $past(mem_en && !mem_we, 2)); // R5
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en || rsp_valid) |-> !req_ready); // R8
endmodule

// File: rtl/bitalias_unit.sv
module bitalias_unit #(
    parameter int ADDR_W = 16,
    parameter int WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic              dec_alias, dec_mis;
    logic [WIDX_W-1:0] dec_dw, dec_aw;
    logic [4:0]        dec_bit;
    logic              mem_en, mem_we;
    logic [WIDX_W-1:0] mem_addr;
    logic [31:0]       mem_wdata, mem_rdata;

    bitalias_decode #(.ADDR_W(ADDR_W), .WIDX_W(WIDX_W)) u_dec (
        .addr(req_addr), .is_alias(dec_alias), .misaligned(dec_mis),
        .direct_widx(dec_dw), .alias_widx(dec_aw), .alias_bidx(dec_bit)
    );

    bitalias_ctrl #(.WIDX_W(WIDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_wdata(req_wdata),
        .dec_alias(dec_alias), .dec_misaligned(dec_mis),
        .dec_direct_widx(dec_dw), .dec_alias_widx(dec_aw), .dec_alias_bidx(dec_bit),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    bitalias_mem #(.WORDS(WORDS), .WIDX_W(WIDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .en(mem_en), .we(mem_we),
        .addr(mem_addr), .wdata(mem_wdata), .rdata(mem_rdata)
    );

    AST_ERR_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> ($past(!mem_en) && rsp_rdata == 32'b0)); // R6
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
endmodule

// File: tb/bitalias_unit_test.sv
module bitalias_unit_test;
    localparam int ADDR_W = 16;
    localparam int WORDS  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_ready, rsp_valid, rsp_err;
    logic [31:0]       rsp_rdata;

    int n_vec = 0;
    int n_bad = 0;
    logic [31:0] model [WORDS];

    always #2 clk = ~clk;

    bitalias_unit #(.ADDR_W(ADDR_W), .WORDS(WORDS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    function automatic logic [ADDR_W-1:0] dir_addr(int w);
        return ADDR_W'(w * 4);
    endfunction

    function automatic logic [ADDR_W-1:0] al_addr(int w, int b);
        return ADDR_W'(32'h8000 | (w << 7) | (b << 2));
    endfunction

    function automatic logic [31:0] bit_of(logic [31:0] v, int b);
        return {31'b0, v[b]};
    endfunction

    function automatic logic [31:0] put_bit(logic [31:0] v, int b, logic nb);
        logic [31:0] r = v;
        r[b] = nb;
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one access; checks latency (R7) and ready low while busy (R8)
    task automatic access(logic wr, logic [ADDR_W-1:0] a, logic [31:0] wd,
                          int exp_lat, output logic [31:0] rd, output logic er);
        int lat = 0;
        @(negedge clk);
        chk("R8 ready idle", {31'b0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(posedge clk);
        forever begin
            @(negedge clk);
            lat++;
            req_valid = 1'b0;
            if (rsp_valid || lat > 20) break;
            if (req_ready !== 1'b0) begin
                chk("R8 ready low while busy", {31'b0, req_ready}, 32'd0);
            end
        end
        rd = rsp_rdata; er = rsp_err;
        chk("R7 latency", lat, exp_lat);
        @(negedge clk);
        chk("R7 single strobe", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic dwrite(int w, logic [31:0] v);
        logic [31:0] rd; logic er;
        access(1'b1, dir_addr(w), v, 2, rd, er);
        model[w] = v;
        chk("R7 write data zero", rd, 32'd0);
    endtask

    task automatic dread(int w, string req);
        logic [31:0] rd; logic er;
        access(1'b0, dir_addr(w), 32'h0, 3, rd, er);
        chk(req, rd, model[w]);
    endtask

    task automatic aread(int w, int b);
        logic [31:0] rd; logic er;
        access(1'b0, al_addr(w, b), 32'h0, 3, rd, er);
        chk("R4 alias read", rd, bit_of(model[w], b));
        chk("R4 no error", {31'b0, er}, 32'd0);
    endtask

    task automatic awrite(int w, int b, logic [31:0] v);
        logic [31:0] rd; logic er;
        access(1'b1, al_addr(w, b), v, 4, rd, er);
        model[w] = put_bit(model[w], b, v[0]);
        chk("R5 alias write response", {rd[30:0], er}, 32'd0);
    endtask

    task automatic amis(logic wr, int w, int b, int low);
        logic [31:0] rd; logic er;
        access(wr, al_addr(w, b) | ADDR_W'(low), 32'hFFFF_FFFF, 1, rd, er);
        chk("R6 error flag", {31'b0, er}, 32'd1);
        chk("R6 error data", rd, 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd; logic er;
        int seed_sink;
        seed_sink = $urandom(32'h00C0FFEE);
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R1 no response after reset", {31'b0, rsp_valid}, 32'd0);
        for (int w = 0; w < WORDS; w++) dread(w, "R1 memory cleared");

        // R2 direct path, full words, upper address bits ignored
        dwrite(3, 32'hA5A5_0F0F);
        dread(3, "R2 direct readback");
        access(1'b0, ADDR_W'(16'h0040 | 16'h000C | 16'h0002), 32'h0, 3, rd, er);
        chk("R2 ignored address bits", rd, model[3]);

        // R3/R4 decode at bit 0 and bit 31, first and last word
        dwrite(0, 32'h8000_0001);
        aread(0, 0); aread(0, 31); aread(0, 1);
        dwrite(WORDS-1, 32'h4000_0000);
        aread(WORDS-1, 30); aread(WORDS-1, 31);

        // R5 only bit 0 of data matters, neighbours kept
        awrite(3, 4, 32'hFFFF_FFFE);
        dread(3, "R5 clear keeps other bits");
        awrite(3, 31, 32'h0000_0001);
        dread(3, "R5 set keeps other bits");
        awrite(WORDS-1, 0, 32'h0000_0003);
        dread(WORDS-1, "R3 last word bit 0");

        // R6 misaligned alias leaves memory alone
        amis(1'b1, 3, 0, 1);
        amis(1'b1, 3, 5, 2);
        amis(1'b0, 3, 5, 3);
        dread(3, "R6 memory unchanged");

        // random mix
        for (int k = 0; k < 400; k++) begin
            int kind = int'($urandom_range(0, 4));
            int w    = int'($urandom_range(0, WORDS-1));
            int b    = int'($urandom_range(0, 31));
            logic [31:0] v = $urandom;
            case (kind)
                0: dwrite(w, v);
                1: dread(w, "R2 random read");
                2: aread(w, b);
                3: awrite(w, b, v);
                default: amis(v[0], w, b, int'($urandom_range(1, 3)));
            endcase
        end
        for (int w = 0; w < WORDS; w++) dread(w, "R5 final contents");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule